// File: doc/BRIEF.md
# Output Channel Occupancy Load Tracker

This block keeps a per-output load figure for congestion-aware routing in a network that has no credits. Rather than counting free slots downstream, it counts the flits that currently sit in one chosen stretch of the output channel. The routing logic uses this figure to compare outputs.

When a routing decision picks this output, the whole packet length is charged at once. Each flit that leaves the watched stretch takes one off the count. Up to five routing decisions can arrive in the same cycle. All of them are summed into the registered count. Each decision also gets its own combinational view of the load, which already includes the packets granted to lower-numbered decision ports in that same cycle. This lets decisions made together take account of each other.

The counter saturates at its top value and never drops below zero.

Top module: `occ_tracker`

## Requirements
- R1: After reset the registered occupancy `occupancy` is 0.
- R2: A decision port i with `decValid[i]`=1 adds its length `decLen[4*i+3:4*i]` to `occupancy` on the next clock edge. A port with `decValid[i]`=0 contributes nothing, whatever its length field holds.
- R3: Lengths from all valid decision ports in one cycle are summed into a single update.
- R4: `flitDepart`=1 with no valid decision lowers `occupancy` by one on the next edge.
- R5: Increments and the departure in one cycle are applied together as one net change: occupancy + sum of lengths − 1.
- R6: Occupancy never goes below zero. A departure while occupancy plus the same-cycle lengths is 0 leaves it at 0.
- R7: Occupancy saturates at 63 (2^6−1). A result above 63, taken after the departure is applied, is stored as 63.
- R8: `seenOcc[6*i+5:6*i]` equals, in the same cycle, `occupancy` plus the lengths of all valid ports with index below i, saturated at 63. Port 0 sees `occupancy` itself.
- R9: A length field above 8 is treated as 8, both in the update and in `seenOcc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| decValid | input | 5 | One bit per routing decision that selects this output this cycle |
| decLen | input | 20 | Packet length per decision port, 4 bits each, port i at bits 4i+3:4i |
| flitDepart | input | 1 | A flit leaves the monitored channel segment |
| occupancy | output | 6 | Registered occupancy count |
| seenOcc | output | 30 | Per-port occupancy as seen by each decision, 6 bits each |

## Verification
There are two kinds of result, and they fall due at different times. The `seenOcc` outputs are combinational, so the bench checks them a short time after it drives the inputs, in the same cycle and before any clock edge. The `occupancy` value changes at the first rising edge after the stimulus, so the bench drives on the falling edge, lets one rising edge pass, and checks on the following falling edge. It compares against a reference next-value function that applies the clamp, the sum, the departure and the saturation in the order the requirements give.

// File: rtl/occ_pkg.sv
package occ_pkg;
  localparam int DEC_PORTS = 5;

  typedef struct packed {
    logic                 depart;
    logic [DEC_PORTS-1:0] take;
  } occCtrl_t;
endpackage

// File: rtl/occ_ctrl.sv
module occ_ctrl
  import occ_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DEC_PORTS-1:0] decValid,
  input  logic                 flitDepart,
  output occCtrl_t             ctrl
);
  always_comb begin
    ctrl.take   = decValid;
    ctrl.depart = flitDepart;
  end

  // R2
  no_phantom_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.take & ~decValid) == '0);
endmodule

// File: rtl/occ_datapath.sv
module occ_datapath
  import occ_pkg::*;
#(
  parameter int LEN_W   = 4,
  parameter int MAX_LEN = 8,
  parameter int OCC_W   = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  occCtrl_t                   ctrl,
  input  logic [DEC_PORTS*LEN_W-1:0] decLen,
  output logic [OCC_W-1:0]           occ,
  output logic [DEC_PORTS*OCC_W-1:0] seen
);
  localparam int WIDE_W  = OCC_W + $clog2(DEC_PORTS*MAX_LEN + 1) + 1;
  localparam int OCC_MAX = (1 << OCC_W) - 1;

  logic [WIDE_W-1:0] effLen  [DEC_PORTS];
  logic [WIDE_W-1:0] prefix  [DEC_PORTS+1];
  logic [WIDE_W-1:0] total;
  logic [WIDE_W-1:0] netVal;
  logic [OCC_W-1:0]  occNext;

  always_comb begin
    prefix[0] = '0;
    for (int i = 0; i < DEC_PORTS; i++) begin
      logic [LEN_W-1:0] raw;
      raw = decLen[i*LEN_W +: LEN_W];
      if (!ctrl.take[i])
        effLen[i] = '0;
      else if (WIDE_W'(raw) > WIDE_W'(MAX_LEN))
        effLen[i] = WIDE_W'(MAX_LEN);
      else
        effLen[i] = WIDE_W'(raw);
      prefix[i+1] = prefix[i] + effLen[i];
    end
  end

  genvar g;
  generate
    for (g = 0; g < DEC_PORTS; g++) begin : gSeen
      logic [WIDE_W-1:0] view;
      assign view = WIDE_W'(occ) + prefix[g];
      assign seen[g*OCC_W +: OCC_W] =
        (view > WIDE_W'(OCC_MAX)) ? OCC_W'(OCC_MAX) : view[OCC_W-1:0];
    end
  endgenerate

  always_comb begin
    total  = WIDE_W'(occ) + prefix[DEC_PORTS];
    netVal = (ctrl.depart && total != '0) ? total - 1'b1 : total;
    occNext = (netVal > WIDE_W'(OCC_MAX)) ? OCC_W'(OCC_MAX) : netVal[OCC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) occ <= '0;
    else       occ <= occNext;
  end

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (occ == '0 && ctrl.take == '0 && ctrl.depart) |=> (occ == '0));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (occ == OCC_W'(OCC_MAX) && !ctrl.depart) |=> (occ == OCC_W'(OCC_MAX)));

  // R4
  depart_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.depart && ctrl.take == '0 && occ != '0) |=> (occ == $past(occ) - 1'b1));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.take == '0 && !ctrl.depart) |=> $stable(occ));

  // R3
  grow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.take != '0 && !ctrl.depart) |=> (occ >= $past(occ)));
endmodule

// File: rtl/occ_tracker.sv
module occ_tracker
  import occ_pkg::*;
#(
  parameter int LEN_W   = 4,
  parameter int MAX_LEN = 8,
  parameter int OCC_W   = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [DEC_PORTS-1:0]       decValid,
  input  logic [DEC_PORTS*LEN_W-1:0] decLen,
  input  logic                       flitDepart,
  output logic [OCC_W-1:0]           occupancy,
  output logic [DEC_PORTS*OCC_W-1:0] seenOcc
);
  occCtrl_t ctrl;

  occ_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .decValid(decValid),
    .flitDepart(flitDepart), .ctrl(ctrl)
  );

  occ_datapath #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN), .OCC_W(OCC_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .decLen(decLen),
    .occ(occupancy), .seen(seenOcc)
  );

  // R8
  port0_view_chk: assert property (@(posedge clk) disable iff (!rstN)
    seenOcc[OCC_W-1:0] == occupancy);
endmodule

// File: tb/occ_tracker_bench.sv
module occ_tracker_bench;
  localparam int N = 5;
  localparam int LW = 4;
  localparam int OW = 6;
  localparam int OMAX = 63;

  logic clk = 0;
  logic rstN = 0;
  logic [N-1:0] decValid = '0;
  logic [N*LW-1:0] decLen = '0;
  logic flitDepart = 0;
  logic [OW-1:0] occupancy;
  logic [N*OW-1:0] seenOcc;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  occ_tracker u_occ_tracker (
    .clk(clk), .rstN(rstN), .decValid(decValid), .decLen(decLen),
    .flitDepart(flitDepart), .occupancy(occupancy), .seenOcc(seenOcc)
  );

  function automatic int clampLen(int v);
    return (v > 8) ? 8 : v;
  endfunction

  function automatic int sat(int v);
    return (v > OMAX) ? OMAX : v;
  endfunction

  function automatic int refNext(int cur, logic [N-1:0] v, logic [N*LW-1:0] l, logic d);
    int t = cur;
    for (int i = 0; i < N; i++) if (v[i]) t += clampLen(int'(l[i*LW +: LW]));
    if (d && t > 0) t -= 1;
    return sat(t);
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(logic [N-1:0] v, int l0, int l1, int l2, int l3, int l4, logic d);
    decValid = v;
    decLen = {LW'(l4), LW'(l3), LW'(l2), LW'(l1), LW'(l0)};
    flitDepart = d;
  endtask

  // drive at negedge, one posedge, check at next negedge
  task automatic step(string req, logic [N-1:0] v, int l0, int l1, int l2, int l3, int l4, logic d);
    int exp;
    drive(v, l0, l1, l2, l3, l4, d);
    exp = refNext(int'(occupancy), decValid, decLen, d);
    @(negedge clk);
    drive('0, 0, 0, 0, 0, 0, 0);
    check(req, int'(occupancy), exp);
  endtask

  task automatic doReset();
    rstN = 0;
    drive('0, 0, 0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    rstN = 1;
  endtask

  task automatic tReset();
    doReset();
    check("R1", int'(occupancy), 0);
  endtask

  task automatic tSingle();
    doReset();
    step("R2", 5'b00001, 3, 0, 0, 0, 0, 0);
    step("R2", 5'b00000, 7, 7, 7, 7, 7, 0);
    check("R2 ignored", int'(occupancy), 3);
  endtask

  task automatic tMulti();
    doReset();
    step("R3", 5'b11111, 1, 2, 3, 4, 5, 0);
    step("R3", 5'b10100, 9, 9, 2, 9, 6, 0);
  endtask

  task automatic tDepart();
    doReset();
    step("R4 setup", 5'b00010, 0, 4, 0, 0, 0, 0);
    step("R4", 5'b00000, 0, 0, 0, 0, 0, 1);
    check("R4 value", int'(occupancy), 3);
  endtask

  task automatic tNet();
    doReset();
    step("R5", 5'b01001, 2, 0, 0, 3, 0, 1);
    check("R5 value", int'(occupancy), 4);
  endtask

  task automatic tUnder();
    doReset();
    step("R6", 5'b00000, 0, 0, 0, 0, 0, 1);
    check("R6 value", int'(occupancy), 0);
    step("R6 zero-len", 5'b00001, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic tSat();
    doReset();
    step("R7", 5'b11111, 8, 8, 8, 8, 8, 0);
    step("R7", 5'b11111, 8, 8, 8, 8, 8, 1);
    check("R7 value", int'(occupancy), 63);
    step("R7 leave", 5'b00000, 0, 0, 0, 0, 0, 1);
    check("R7 leave value", int'(occupancy), 62);
  endtask

  task automatic tSeen();
    doReset();
    step("R8 setup", 5'b00001, 6, 0, 0, 0, 0, 0);
    drive(5'b10111, 2, 3, 5, 7, 1, 0);
    #1;
    check("R8 p0", int'(seenOcc[0*OW +: OW]), 6);
    check("R8 p1", int'(seenOcc[1*OW +: OW]), 8);
    check("R8 p2", int'(seenOcc[2*OW +: OW]), 11);
    check("R8 p3", int'(seenOcc[3*OW +: OW]), 16);
    check("R8 p4", int'(seenOcc[4*OW +: OW]), 16);
    @(negedge clk);
    drive('0, 0, 0, 0, 0, 0, 0);
    check("R8 reg", int'(occupancy), 17);
    step("R8 fill", 5'b11111, 8, 8, 8, 8, 8, 0);
    drive(5'b11111, 8, 8, 8, 8, 8, 0);
    #1;
    check("R8 sat p4", int'(seenOcc[4*OW +: OW]), 63);
    @(negedge clk);
    drive('0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic tClamp();
    doReset();
    drive(5'b00011, 15, 12, 0, 0, 0, 0);
    #1;
    check("R9 seen", int'(seenOcc[1*OW +: OW]), 8);
    @(negedge clk);
    drive('0, 0, 0, 0, 0, 0, 0);
    check("R9", int'(occupancy), 16);
  endtask

  initial begin
    @(negedge clk);
    tReset();
    tSingle();
    tMulti();
    tDepart();
    tNet();
    tUnder();
    tSat();
    tSeen();
    tClamp();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule